// File: doc/BRIEF.md
# Convolution patch column streamer

This block turns input feature maps held in an on-chip buffer into the column layout that lets a convolution layer run as a plain matrix product. For every output pixel it produces one column that gathers all input values under the filter window, taken from every input channel. The weight filters are assumed to be flattened elsewhere into rows of the same length. A downstream multiplier then computes the full layer as weight matrix × patch matrix. The block only rearranges data: it does not multiply, hold weights or fill the buffer.

A one-cycle `start` pulse begins a frame. The block steps through output positions row by row. At each position it walks the window in the order channel, kernel row, kernel column. For each element it either reads the feature-map buffer through an address/data port, or emits a zero when the element lies in the padding border. Elements leave through a valid/ready stream. The first element of each column carries a start marker and the last carries an end marker. Buffer reads have a fixed one-cycle latency. A small two-slot output queue, with credit-based issue, hides that latency so the block sustains one element per clock while the consumer accepts.

Stride, padding, kernel size, channel count and input size are all parameters. Output size is derived as (in + 2·pad − k)/stride + 1 in each dimension.

Top module: `im2col_streamer`

## Requirements
- R1: Each column holds C_IN·K·K elements. `out_first` is high on the column's first element only, and `out_last` is high on its final element only.
- R2: Within a column, elements are ordered by channel, then kernel row, then kernel column. The buffer is addressed channel-major: channel·IN_H·IN_W + row·IN_W + col. The element at kernel offset (ky,kx) of output (oy,ox) uses input row oy·STRIDE+ky−PAD and input column ox·STRIDE+kx−PAD.
- R3: Columns are emitted in raster order of output position: output row by output row, left to right. A frame holds OUT_H·OUT_W columns.
- R4: An element whose input row or column falls outside the map is emitted as zero, and no buffer read (`rd_en`) is issued for it. Every other element causes exactly one read.
- R5: `rd_data` is taken as valid in the cycle after `rd_en` is high, and is forwarded unchanged.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` hold their values.
- R7: With `out_ready` held high, a frame of N elements is fully delivered within N+4 clock cycles of the `start` pulse.
- R8: `start` is acted on only while `busy` is low. `busy` is high from the cycle after an accepted `start` until the frame's last element has been accepted. A `start` seen while busy has no effect.
- R9: During reset, `out_valid`, `busy` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one frame when idle |
| busy | output | 1 | Frame in progress |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | DATA_W | Buffer read data, one cycle after `rd_en` |
| out_valid | output | 1 | Column element available |
| out_ready | input | 1 | Consumer accepts element |
| out_data | output | DATA_W | Column element value |
| out_first | output | 1 | Element is first of its column |
| out_last | output | 1 | Element is last of its column |

## Verification
The properties assume that the buffer answers every `rd_en` with data in the next cycle, and that its contents do not change during a frame. They also assume that `start` is a single-cycle pulse. `out_ready` may follow any pattern. The bench models the buffer as a registered lookup whose value is a fixed function of the address, so contents never change. It drives `start` for exactly one cycle, including one pulse in the middle of a frame, and it varies `out_ready` as always-high, alternating and pseudo-random.

// File: rtl/im2col_pkg.sv
package im2col_pkg;

  // Output extent of one spatial dimension of a strided, padded window walk.
  function automatic int out_dim(input int in_sz, input int k, input int s, input int p);
    return (in_sz + 2 * p - k) / s + 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Column framing carried alongside each element.
  typedef struct packed {
    logic first;
    logic last;
  } mark_t;

endpackage

// File: rtl/im2col_dim_cnt.sv
// One wrapping dimension counter of the window walk.
module im2col_dim_cnt #(
  parameter int LIMIT = 3,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         at_max
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign at_max = (cnt_q == W'(LIMIT - 1));
  assign cnt_en = clr | inc;
  assign value  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = at_max ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/im2col_walker.sv
// Nested counter chain: kernel col (fastest), kernel row, channel,
// output col, output row (slowest).
module im2col_walker #(
  parameter int C_IN  = 3,
  parameter int K     = 3,
  parameter int OUT_H = 4,
  parameter int OUT_W = 4,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] kx,
  output logic [CW-1:0] ky,
  output logic [CW-1:0] ch,
  output logic [CW-1:0] ox,
  output logic [CW-1:0] oy,
  output logic          col_first,
  output logic          col_last,
  output logic          frame_last
);

  localparam int NDIM = 5;
  localparam int LIMS [NDIM] = '{K, K, C_IN, OUT_W, OUT_H};

  logic [CW-1:0]   val [NDIM];
  logic [NDIM-1:0] top;
  logic [NDIM-1:0] inc;

  assign inc[0] = step;

  generate
    for (genvar g = 1; g < NDIM; g++) begin : g_carry
      assign inc[g] = inc[g-1] & top[g-1];
    end
    for (genvar g = 0; g < NDIM; g++) begin : g_dim
      im2col_dim_cnt #(
        .LIMIT (LIMS[g]),
        .W     (CW)
      ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (inc[g]),
        .value  (val[g]),
        .at_max (top[g])
      );
    end
  endgenerate

  assign kx = val[0];
  assign ky = val[1];
  assign ch = val[2];
  assign ox = val[3];
  assign oy = val[4];

  assign col_first  = (val[0] == '0) && (val[1] == '0) && (val[2] == '0);
  assign col_last   = &top[2:0];
  assign frame_last = &top;

endmodule

// File: rtl/im2col_addr.sv
// Maps a walk position to a buffer address and flags padding positions.
module im2col_addr #(
  parameter int IN_H   = 8,
  parameter int IN_W   = 8,
  parameter int STRIDE = 1,
  parameter int PAD    = 0,
  parameter int CW     = 4,
  parameter int AW     = 8
) (
  input  logic [CW-1:0] kx,
  input  logic [CW-1:0] ky,
  input  logic [CW-1:0] ch,
  input  logic [CW-1:0] ox,
  input  logic [CW-1:0] oy,
  output logic [AW-1:0] addr,
  output logic          is_pad
);

  localparam int PLANE = IN_H * IN_W;

  int iy_i;
  int ix_i;
  int lin_i;

  always_comb begin
    iy_i   = int'(oy) * STRIDE + int'(ky) - PAD;
    ix_i   = int'(ox) * STRIDE + int'(kx) - PAD;
    is_pad = (iy_i < 0) || (iy_i >= IN_H) || (ix_i < 0) || (ix_i >= IN_W);
    lin_i  = is_pad ? 0 : int'(ch) * PLANE + iy_i * IN_W + ix_i;
    addr   = AW'(lin_i);
  end

endmodule

// File: rtl/im2col_out_fifo.sv
// Two-slot output queue; absorbs the read in flight when the consumer stalls.
module im2col_out_fifo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         head_valid,
  output logic [1:0]   count
);

  logic [W-1:0] slot_q [2];
  logic         wr_q, wr_d;
  logic         rd_q, rd_d;
  logic [1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q ^ push;
    rd_d  = rd_q ^ pop;
    cnt_d = cnt_q + {1'b0, push} - {1'b0, pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_q[wr_q] <= push_data;
    end
  end

  assign head_data  = slot_q[rd_q];
  assign head_valid = (cnt_q != 2'd0);
  assign count      = cnt_q;

endmodule

// File: rtl/im2col_streamer.sv
module im2col_streamer
  import im2col_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int C_IN   = 3,
  parameter int IN_H   = 227,
  parameter int IN_W   = 227,
  parameter int K      = 11,
  parameter int STRIDE = 4,
  parameter int PAD    = 0,
  parameter int ADDR_W = $clog2(C_IN * IN_H * IN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last
);

  localparam int OUT_H  = out_dim(IN_H, K, STRIDE, PAD);
  localparam int OUT_W  = out_dim(IN_W, K, STRIDE, PAD);
  localparam int MAXDIM = max2(max2(C_IN, K), max2(OUT_H, OUT_W));
  localparam int CW     = $clog2(MAXDIM + 1);
  localparam int QW     = DATA_W + 2;
  localparam int QDEPTH = 2;

  // walk position
  logic [CW-1:0] kx, ky, ch, ox, oy;
  logic          col_first, col_last, frame_last;
  logic [ADDR_W-1:0] addr;
  logic          is_pad;

  // control
  logic running_q, running_d;
  logic start_go, issue, pop, space;
  logic [2:0] occ;

  // read stage (element whose buffer data arrives this cycle)
  logic  s1_v_q, s1_pad_q;
  mark_t s1_mark_q;
  logic  s1_v_d, s1_pad_d;
  mark_t s1_mark_d;

  // output queue
  logic [QW-1:0]     q_in, q_head;
  logic              q_valid;
  logic [1:0]        q_cnt;
  logic [DATA_W-1:0] s1_value;
  mark_t             head_mark;

  im2col_walker #(
    .C_IN  (C_IN),
    .K     (K),
    .OUT_H (OUT_H),
    .OUT_W (OUT_W),
    .CW    (CW)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_go),
    .step       (issue),
    .kx         (kx),
    .ky         (ky),
    .ch         (ch),
    .ox         (ox),
    .oy         (oy),
    .col_first  (col_first),
    .col_last   (col_last),
    .frame_last (frame_last)
  );

  im2col_addr #(
    .IN_H   (IN_H),
    .IN_W   (IN_W),
    .STRIDE (STRIDE),
    .PAD    (PAD),
    .CW     (CW),
    .AW     (ADDR_W)
  ) u_addr (
    .kx     (kx),
    .ky     (ky),
    .ch     (ch),
    .ox     (ox),
    .oy     (oy),
    .addr   (addr),
    .is_pad (is_pad)
  );

  // Credit: an element may be issued only if a queue slot is certain to be
  // free when its data lands one cycle later.
  always_comb begin
    pop      = q_valid & out_ready;
    occ      = {1'b0, q_cnt} + {2'b00, s1_v_q};
    space    = (occ - {2'b00, pop}) < 3'(QDEPTH);
    busy     = running_q | s1_v_q | q_valid;
    start_go = start & ~busy;
    issue    = running_q & space;
  end

  // next state
  always_comb begin
    running_d = running_q;
    if (start_go) begin
      running_d = 1'b1;
    end else if (issue && frame_last) begin
      running_d = 1'b0;
    end
    s1_v_d          = issue;
    s1_pad_d        = is_pad;
    s1_mark_d.first = col_first;
    s1_mark_d.last  = col_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      s1_v_q    <= 1'b0;
    end else begin
      running_q <= running_d;
      s1_v_q    <= s1_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_pad_q  <= 1'b0;
      s1_mark_q <= '0;
    end else if (issue) begin
      s1_pad_q  <= s1_pad_d;
      s1_mark_q <= s1_mark_d;
    end
  end

  assign rd_en    = issue & ~is_pad;
  assign rd_addr  = addr;
  assign s1_value = s1_pad_q ? '0 : rd_data;
  assign q_in     = {s1_mark_q, s1_value};

  im2col_out_fifo #(
    .W (QW)
  ) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (s1_v_q),
    .push_data  (q_in),
    .pop        (pop),
    .head_data  (q_head),
    .head_valid (q_valid),
    .count      (q_cnt)
  );

  assign head_mark = q_head[QW-1 -: 2];
  assign out_valid = q_valid;
  assign out_data  = q_head[DATA_W-1:0];
  assign out_first = head_mark.first;
  assign out_last  = head_mark.last;

endmodule

// File: rtl/im2col_streamer_chk.sv
module im2col_streamer_chk #(
  parameter int DATA_W = 16,
  parameter int C_IN   = 3,
  parameter int IN_H   = 227,
  parameter int IN_W   = 227,
  parameter int K      = 11,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_first,
  input logic              out_last
);

  localparam int COL_LEN = C_IN * K * K;
  localparam int TOTAL   = C_IN * IN_H * IN_W;
  localparam int BW      = $clog2(COL_LEN + 1);

  logic [BW-1:0] beat_q;
  logic          xfer;

  assign xfer = out_valid & out_ready;

  // independent count of accepted elements within the current column
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (xfer) begin
      beat_q <= (beat_q == BW'(COL_LEN - 1)) ? '0 : beat_q + BW'(1);
    end
  end

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));

  a_r1_first_marker: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (out_first == (beat_q == '0)));

  a_r1_last_marker: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (out_last == (beat_q == BW'(COL_LEN - 1))));

  a_r4_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_addr) < TOTAL));

  a_r8_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !rd_en);

endmodule

bind im2col_streamer im2col_streamer_chk #(
  .DATA_W (DATA_W),
  .C_IN   (C_IN),
  .IN_H   (IN_H),
  .IN_W   (IN_W),
  .K      (K),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_first (out_first),
  .out_last  (out_last)
);

// File: tb/im2col_streamer_test.sv
`timescale 1ns/1ps
module im2col_streamer_test;

  localparam int DW   = 16;
  localparam int C    = 2;
  localparam int H    = 5;
  localparam int W    = 5;
  localparam int K    = 3;
  localparam int S    = 2;
  localparam int P    = 1;
  localparam int OH   = (H + 2 * P - K) / S + 1;
  localparam int OW   = (W + 2 * P - K) / S + 1;
  localparam int COLN = C * K * K;
  localparam int NCOL = OH * OW;
  localparam int NEL  = COLN * NCOL;
  localparam int AW   = $clog2(C * H * W);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          busy;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_first;
  logic          out_last;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_d [NEL];
  bit            exp_f [NEL];
  bit            exp_l [NEL];
  int            exp_reads;

  always #2.5 clk = ~clk;

  im2col_streamer #(
    .DATA_W (DW), .C_IN (C), .IN_H (H), .IN_W (W),
    .K (K), .STRIDE (S), .PAD (P), .ADDR_W (AW)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .busy (busy),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .out_first (out_first), .out_last (out_last)
  );

  function automatic logic [DW-1:0] mem_val(input int a);
    return DW'(a * 37 + 1000);
  endfunction

  // buffer model: registered, one cycle latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem_val(int'(rd_addr));
      rd_cnt  <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // software model of the rearrangement
  task automatic build_model();
    int i = 0;
    exp_reads = 0;
    for (int oy = 0; oy < OH; oy++)
      for (int ox = 0; ox < OW; ox++)
        for (int c = 0; c < C; c++)
          for (int ky = 0; ky < K; ky++)
            for (int kx = 0; kx < K; kx++) begin
              int iy = oy * S + ky - P;
              int ix = ox * S + kx - P;
              bit pad = (iy < 0) || (iy >= H) || (ix < 0) || (ix >= W);
              exp_d[i] = pad ? '0 : mem_val(c * H * W + iy * W + ix);
              if (!pad) exp_reads++;
              exp_f[i] = (c == 0) && (ky == 0) && (kx == 0);
              exp_l[i] = (c == C - 1) && (ky == K - 1) && (kx == K - 1);
              i++;
            end
  endtask

  // mode 0: ready high, 1: alternating, 2: pseudo-random
  task automatic run_frame(input int mode, input bit restart_mid, output int cycles);
    int idx = 0;
    int lasts = 0;
    int rd0 = rd_cnt;
    logic [7:0] lf = 8'hA5;
    bit hold_v = 1'b0;
    logic [DW-1:0] held_d = '0;
    bit held_f = 1'b0, held_l = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles = 1;
    check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
    while (idx < NEL && cycles < 5000) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (cycles % 2 == 0);
        default: out_ready = lf[0];
      endcase
      start = restart_mid && (cycles == 20);
      #1;
      if (hold_v) begin
        check(out_valid && out_data == held_d && out_first == held_f && out_last == held_l,
              "R6", "stalled element changed", int'(out_data), int'(held_d));
      end
      hold_v = out_valid && !out_ready;
      held_d = out_data; held_f = out_first; held_l = out_last;
      if (out_valid && out_ready) begin
        check(out_data == exp_d[idx], "R2 R4 R5", $sformatf("data of element %0d", idx),
              int'(out_data), int'(exp_d[idx]));
        check(out_first == exp_f[idx] && out_last == exp_l[idx], "R1",
              $sformatf("markers of element %0d", idx),
              int'({out_first, out_last}), int'({exp_f[idx], exp_l[idx]}));
        if (out_last) lasts++;
        idx++;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check(idx == NEL, "R3", "elements delivered", idx, NEL);
    check(lasts == NCOL, "R3", "columns delivered", lasts, NCOL);
    check(rd_cnt - rd0 == exp_reads, "R4", "buffer reads in frame", rd_cnt - rd0, exp_reads);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R8", "idle after frame",
          int'({busy, out_valid}), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    check(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    check(rd_en == 1'b0, "R9", "rd_en in reset", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_full_rate();
    int cyc;
    run_frame(0, 1'b0, cyc);
    check(cyc <= NEL + 4, "R7", "cycles for a frame at full rate", cyc, NEL + 4);
  endtask

  task automatic t_alternating_ready();
    int cyc;
    run_frame(1, 1'b0, cyc);
  endtask

  task automatic t_random_ready();
    int cyc;
    run_frame(2, 1'b0, cyc);
  endtask

  task automatic t_start_while_busy();
    int cyc;
    run_frame(0, 1'b1, cyc);
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0 && busy == 1'b0, "R8", "extra start ignored",
          int'({busy, out_valid}), 0);
  endtask

  initial begin
    build_model();
    t_reset();
    t_full_rate();
    t_alternating_ready();
    t_random_ready();
    t_start_while_busy();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule